// File: doc/BRIEF.md
# Configuration Access Port Decoder

This block is the I/O-side front end of a host bridge's configuration access path. Software reaches configuration space through two windows in an eight-byte I/O range. The lower four bytes hold a 32-bit address latch. The upper four bytes form a data window. The latch names a bus, a device/function, a dword register index (including four extended index bits) and an enable flag. A data-window access made while the flag is set becomes a single configuration request, with lane byte enables, sent to a downstream agent.

The I/O side uses a valid/ready handshake. The requester holds `io_valid` and the access fields steady until `io_ready` is high for one cycle, then drops `io_valid`. Read data comes back right-justified, and bits above the access width are zero. The downstream agent answers a held `cfg_req` with a one-cycle `cfg_ack`. With that acknowledge it returns either lane-positioned read data or a no-device flag. Bit 0 of latch byte 3 has a second job: a sub-dword write to that byte stores it in a separate mode flag, which is brought out as a pin.

Top module: `cfgap_port`

## Requirements
- R1: After reset the address latch and the mode flag read as zero, `io_ready` is low and `cfg_req` is low.
- R2: A dword write at offset 0 loads all 32 latch bits and leaves the mode flag unchanged. A dword read at offset 0 then returns exactly the value written (for example 0x8000_0000).
- R3: Byte and word writes at offsets 0 to 3 change only the selected latch bytes. Reads of the latch at any size return the selected bytes right-justified, with the upper bits zero.
- R4: A byte or word write that covers latch byte 3 copies its bit 0 into the mode flag (`mode_flag`), keeps latch bit 24 unchanged and writes bits 31:25 normally.
- R5: A data-window access (offsets 4 to 7) made while latch bit 31 is clear raises no `cfg_req`. A read returns all ones in the accessed width. A write changes nothing.
- R6: While latch bit 31 is set, a data-window access raises `cfg_req`. The request carries bus = latch[23:16], devfn = latch[15:8] and `cfg_reg` = {latch[27:24], latch[7:2]} (a 10-bit dword index), plus the access direction.
- R7: Size encoding is 0 = byte, 1 = word, 2 = dword. For a byte at window offset n, `cfg_be` = 1<<n. For a word, `cfg_be` is 0011 or 1100, chosen by offset bit 1. For a dword, `cfg_be` is 1111. Write data is shifted onto the selected lanes.
- R8: A forwarded read returns `cfg_rdata` shifted down from the selected lanes, masked to the access width.
- R9: When `cfg_nodev` comes with the acknowledge, a read returns all ones in the accessed width.
- R10: `io_ready` is high for exactly one cycle per access. A latch access or a gated access completes one cycle after `io_valid` is sampled. A forwarded access completes one cycle after `cfg_ack`. `cfg_req` and its fields stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | I/O access request |
| io_write | input | 1 | 1 = write, 0 = read |
| io_off | input | 3 | Byte offset in the 8-byte port range |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Write data, right-justified |
| io_ready | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read data, right-justified, valid with io_ready |
| mode_flag | output | 1 | Separately held mode-select bit |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_write | output | 1 | Request direction |
| cfg_bus | output | 8 | Target bus |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 10 | Dword register index including extended bits |
| cfg_be | output | 4 | Lane byte enables |
| cfg_wdata | output | 32 | Lane-positioned write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Lane-positioned read data |
| cfg_nodev | input | 1 | No device answered |

## Verification
The bench builds the block with `EXT_EN` = 1, so the four extended index bits reach `cfg_reg`. Random latch values can therefore reach registers above the first 256 bytes. The downstream model uses acknowledge delays of zero to three cycles. This covers a same-cycle acknowledge as well as a request held over several cycles. Random offsets and sizes cover every byte-enable pattern, both half-word choices, and sub-dword writes that split latch byte 3 between the latch and the mode flag.

// File: rtl/cfgap_pkg.sv
package cfgap_pkg;
    localparam int DW    = 32;
    localparam int NLANE = DW / 8;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic             write;
        logic [7:0]       bus;
        logic [7:0]       devfn;
        logic [9:0]       reg_idx;
        logic [NLANE-1:0] be;
        logic [DW-1:0]    wdata;
    } cfg_req_t;

    function automatic logic [1:0] lane_of(input logic [1:0] off, input acc_size_e sz);
        case (sz)
            ACC_BYTE: return off;
            ACC_WORD: return {off[1], 1'b0};
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic [NLANE-1:0] be_of(input logic [1:0] off, input acc_size_e sz);
        case (sz)
            ACC_BYTE: return NLANE'(1) << lane_of(off, sz);
            ACC_WORD: return NLANE'(3) << lane_of(off, sz);
            default:  return '1;
        endcase
    endfunction

    function automatic logic [DW-1:0] mask_of(input acc_size_e sz);
        case (sz)
            ACC_BYTE: return DW'(8'hFF);
            ACC_WORD: return DW'(16'hFFFF);
            default:  return '1;
        endcase
    endfunction
endpackage

// File: rtl/cfgap_lane_steer.sv
module cfgap_lane_steer
    import cfgap_pkg::*;
(
    input  logic [1:0]       off,
    input  acc_size_e        sz,
    input  logic [DW-1:0]    wdata,
    output logic [1:0]       lane,
    output logic [NLANE-1:0] be,
    output logic [DW-1:0]    wlane,
    output logic [DW-1:0]    mask
);
    always_comb begin
        lane  = lane_of(off, sz);
        be    = be_of(off, sz);
        mask  = mask_of(sz);
        wlane = (wdata & mask) << {lane, 3'b000};
    end
endmodule

// File: rtl/cfgap_addr_reg.sv
module cfgap_addr_reg
    import cfgap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sub_dword,
    input  logic [NLANE-1:0] be,
    input  logic [DW-1:0]    wlane,
    output logic [DW-1:0]    addr_q,
    output logic             mode_q
);
    localparam int TOP = NLANE - 1;

    logic [7:0] byte_q [NLANE];

    // Lanes below the top one are plain byte registers; the top lane's bit 0
    // is diverted to the mode flag on sub-dword writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLANE; i++) byte_q[i] <= '0;
            mode_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < TOP; i++)
                if (be[i]) byte_q[i] <= wlane[8*i +: 8];
            if (be[TOP]) begin
                if (sub_dword) begin
                    byte_q[TOP] <= {wlane[8*TOP+1 +: 7], byte_q[TOP][0]};
                    mode_q      <= wlane[8*TOP];
                end else begin
                    byte_q[TOP] <= wlane[8*TOP +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_pack
        assign addr_q[8*g +: 8] = byte_q[g];
    end
endmodule

// File: rtl/cfgap_ctrl.sv
module cfgap_ctrl
    import cfgap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic             is_win,
    input  logic [DW-1:0]    addr_q,
    input  logic [9:0]       reg_idx,
    input  logic [1:0]       lane,
    input  logic [NLANE-1:0] be,
    input  logic [DW-1:0]    wlane,
    input  logic [DW-1:0]    mask,
    input  logic             cfg_ack,
    input  logic [DW-1:0]    cfg_rdata,
    input  logic             cfg_nodev,
    output logic             reg_wr,
    output logic             io_ready,
    output logic [DW-1:0]    io_rdata,
    output logic             req_v,
    output cfg_req_t         req
);
    ctrl_state_e   state;
    logic [1:0]    lane_q;
    logic [DW-1:0] mask_q;
    logic          fwd;

    assign fwd      = is_win && addr_q[DW-1];
    assign reg_wr   = (state == ST_IDLE) && io_valid && !is_win && io_write;
    assign io_ready = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_v    <= 1'b0;
            req      <= '0;
            io_rdata <= '0;
            lane_q   <= '0;
            mask_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (io_valid) begin
                    lane_q <= lane;
                    mask_q <= mask;
                    if (fwd) begin
                        req_v         <= 1'b1;
                        req.write     <= io_write;
                        req.bus       <= addr_q[23:16];
                        req.devfn     <= addr_q[15:8];
                        req.reg_idx   <= reg_idx;
                        req.be        <= be;
                        req.wdata     <= wlane;
                        state         <= ST_FWD;
                    end else begin
                        io_rdata <= is_win ? mask : ((addr_q >> {lane, 3'b000}) & mask);
                        state    <= ST_DONE;
                    end
                end
                ST_FWD: if (cfg_ack) begin
                    req_v    <= 1'b0;
                    io_rdata <= cfg_nodev ? mask_q : ((cfg_rdata >> {lane_q, 3'b000}) & mask_q);
                    state    <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgap_port.sv
module cfgap_port
    import cfgap_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_valid,
    input  logic        io_write,
    input  logic [2:0]  io_off,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic        io_ready,
    output logic [31:0] io_rdata,
    output logic        mode_flag,
    output logic        cfg_req,
    output logic        cfg_write,
    output logic [7:0]  cfg_bus,
    output logic [7:0]  cfg_devfn,
    output logic [9:0]  cfg_reg,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata,
    input  logic        cfg_nodev
);
    acc_size_e        sz;
    logic [1:0]       lane;
    logic [NLANE-1:0] be;
    logic [DW-1:0]    wlane;
    logic [DW-1:0]    mask;
    logic [DW-1:0]    addr_q;
    logic [9:0]       reg_idx;
    logic             reg_wr;
    cfg_req_t         req;

    assign sz = acc_size_e'(io_size);

    if (EXT_EN) begin : g_ext
        assign reg_idx = {addr_q[27:24], addr_q[7:2]};
    end else begin : g_base
        assign reg_idx = {4'b0000, addr_q[7:2]};
    end

    cfgap_lane_steer u_steer (
        .off   (io_off[1:0]),
        .sz    (sz),
        .wdata (io_wdata),
        .lane  (lane),
        .be    (be),
        .wlane (wlane),
        .mask  (mask)
    );

    cfgap_addr_reg u_addr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .sub_dword (sz != ACC_DWORD && sz != ACC_RSVD),
        .be        (be),
        .wlane     (wlane),
        .addr_q    (addr_q),
        .mode_q    (mode_flag)
    );

    cfgap_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .io_valid  (io_valid),
        .io_write  (io_write),
        .is_win    (io_off[2]),
        .addr_q    (addr_q),
        .reg_idx   (reg_idx),
        .lane      (lane),
        .be        (be),
        .wlane     (wlane),
        .mask      (mask),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata),
        .cfg_nodev (cfg_nodev),
        .reg_wr    (reg_wr),
        .io_ready  (io_ready),
        .io_rdata  (io_rdata),
        .req_v     (cfg_req),
        .req       (req)
    );

    assign cfg_write = req.write;
    assign cfg_bus   = req.bus;
    assign cfg_devfn = req.devfn;
    assign cfg_reg   = req.reg_idx;
    assign cfg_be    = req.be;
    assign cfg_wdata = req.wdata;
endmodule

// File: rtl/cfgap_checker.sv
module cfgap_checker (
    input logic        clk,
    input logic        rst,
    input logic        io_ready,
    input logic        cfg_req,
    input logic        cfg_ack,
    input logic [7:0]  cfg_bus,
    input logic [7:0]  cfg_devfn,
    input logic [9:0]  cfg_reg,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] addr_q
);
    a_r10_ready_single: assert property (@(posedge clk) disable iff (rst)
        io_ready |=> !io_ready);

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_be) && $stable(cfg_reg)
                                   && $stable(cfg_wdata) && $stable(cfg_bus)));

    a_r10_ack_done: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_ack) |=> (io_ready && !cfg_req));

    a_r5_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req) |-> addr_q[31]);

    a_r6_target: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_bus == addr_q[23:16] && cfg_devfn == addr_q[15:8]));

    a_r7_be_shape: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011
                     || cfg_be == 4'b1100 || cfg_be == 4'b1111));

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> !io_ready);
endmodule

bind cfgap_port cfgap_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_ready  (io_ready),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .cfg_bus   (cfg_bus),
    .cfg_devfn (cfg_devfn),
    .cfg_reg   (cfg_reg),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .addr_q    (addr_q)
);

// File: tb/cfgap_port_tb.sv
module cfgap_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [2:0]  io_off = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, mode_flag, cfg_req, cfg_write;
    logic [31:0] io_rdata, cfg_wdata;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [9:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic        cfg_ack = 1'b0, cfg_nodev = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_addr = '0;
    logic        m_flag = 1'b0;

    // downstream model state
    bit          seen_req;
    logic        s_write;
    logic [7:0]  s_bus, s_devfn;
    logic [9:0]  s_reg;
    logic [3:0]  s_be;
    logic [31:0] s_wdata, r_data;
    bit          r_nodev, want_nodev;

    always #10 clk = ~clk;

    cfgap_port #(.EXT_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_off(io_off), .io_size(io_size), .io_wdata(io_wdata),
        .io_ready(io_ready), .io_rdata(io_rdata), .mode_flag(mode_flag),
        .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_bus(cfg_bus),
        .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .cfg_nodev(cfg_nodev)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] f_lane(input logic [1:0] off, input logic [1:0] sz);
        return (sz == 2'd0) ? off : (sz == 2'd1) ? {off[1], 1'b0} : 2'd0;
    endfunction
    function automatic logic [3:0] f_be(input logic [1:0] off, input logic [1:0] sz);
        return (sz == 2'd0) ? (4'b0001 << off) : (sz == 2'd1) ? (off[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    endfunction
    function automatic logic [31:0] f_mask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // downstream responder
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_req && !cfg_ack) begin
                seen_req = 1;
                s_write = cfg_write; s_bus = cfg_bus; s_devfn = cfg_devfn;
                s_reg = cfg_reg; s_be = cfg_be; s_wdata = cfg_wdata;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                r_data = $urandom; r_nodev = want_nodev;
                cfg_rdata = r_data; cfg_nodev = r_nodev; cfg_ack = 1'b1;
                @(negedge clk);
                cfg_ack = 1'b0; cfg_nodev = 1'b0;
            end
        end
    end

    // one access; starts and ends just after a falling edge
    task automatic access(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, input bit nodev, output logic [31:0] rd);
        logic [1:0]  ln = f_lane(off[1:0], sz);
        logic [3:0]  be = f_be(off[1:0], sz);
        logic [31:0] mk = f_mask(sz);
        logic [31:0] wl = (wd & mk) << (8 * ln);
        bit fwd = off[2] && m_addr[31];
        int n = 0;
        seen_req = 0; want_nodev = nodev;
        io_valid = 1; io_write = wr; io_off = off; io_size = sz; io_wdata = wd;
        do begin
            @(negedge clk); n++;
        end while (!io_ready && n < 40);
        rd = io_rdata;
        io_valid = 0;
        if (!fwd) chk("R10 latency", n, 1);
        chk(fwd ? "R6 forwarded" : "R5 not forwarded", 32'(seen_req), 32'(fwd));
        if (fwd) begin
            chk("R6 bus", 32'(s_bus), 32'(m_addr[23:16]));
            chk("R6 devfn", 32'(s_devfn), 32'(m_addr[15:8]));
            chk("R6 reg", 32'(s_reg), 32'({m_addr[27:24], m_addr[7:2]}));
            chk("R6 dir", 32'(s_write), 32'(wr));
            chk("R7 be", 32'(s_be), 32'(be));
            if (wr) chk("R7 wdata", s_wdata & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}}, wl);
            else if (r_nodev) chk("R9 nodev read", rd, mk);
            else chk("R8 read steer", rd, (r_data >> (8 * ln)) & mk);
        end else if (off[2]) begin
            if (!wr) chk("R5 gated read", rd, mk);
        end else if (!wr) begin
            chk(sz == 2'd2 ? "R2 latch read" : "R3 latch read", rd, (m_addr >> (8 * ln)) & mk);
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (be[i]) begin
                    if (i == 3 && sz != 2'd2) begin
                        m_addr[31:25] = wl[31:25];
                        m_flag = wl[24];
                    end else m_addr[8*i +: 8] = wl[8*i +: 8];
                end
            end
        end
        @(negedge clk);
        chk("R10 ready single", 32'(io_ready), 0);
        chk("R4 mode flag", 32'(mode_flag), 32'(m_flag));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd, saved;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(io_ready), 0);
        chk("R1 req", 32'(cfg_req), 0);
        chk("R1 flag", 32'(mode_flag), 0);
        access(0, 3'd0, 2'd2, 0, 0, rd);
        chk("R1 latch zero", rd, 0);

        // probe-like sequence: R4 then R2
        access(1, 3'd3, 2'd0, 32'h01, 0, rd);
        chk("R4 flag set", 32'(mode_flag), 1);
        access(0, 3'd0, 2'd2, 0, 0, saved);
        access(1, 3'd0, 2'd2, 32'h8000_0000, 0, rd);
        access(0, 3'd0, 2'd2, 0, 0, rd);
        chk("R2 exact readback", rd, 32'h8000_0000);
        chk("R2 flag kept", 32'(mode_flag), 1);
        access(1, 3'd0, 2'd2, saved, 0, rd);
        access(0, 3'd0, 2'd2, 0, 0, rd);
        chk("R2 restore", rd, saved);

        // R5 gated window
        access(1, 3'd0, 2'd2, 32'h0012_3456, 0, rd);
        access(0, 3'd5, 2'd0, 0, 0, rd);
        chk("R5 byte ones", rd, 32'hFF);
        access(1, 3'd4, 2'd2, 32'hDEAD_BEEF, 0, rd);

        // R6 extended index, R9 no device
        access(1, 3'd0, 2'd2, 32'h8F12_34FC, 0, rd);
        access(0, 3'd6, 2'd1, 0, 1, rd);
        access(0, 3'd7, 2'd0, 0, 0, rd);
        access(1, 3'd5, 2'd1, 32'hABCD, 0, rd);

        // R3 sub-dword latch writes
        access(1, 3'd1, 2'd0, 32'h5A, 0, rd);
        access(1, 3'd2, 2'd1, 32'h9876, 0, rd);
        access(0, 3'd2, 2'd1, 0, 0, rd);

        for (int k = 0; k < 600; k++) begin
            bit wr = $urandom_range(0, 1);
            logic [2:0] off = 3'($urandom_range(0, 7));
            logic [1:0] sz = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 9) == 0) begin
                logic [31:0] v = $urandom;
                if ($urandom_range(0, 9) < 7) v[31] = 1'b1;
                access(1, 3'd0, 2'd2, v, 0, rd);
            end
            access(wr, off, sz, $urandom, $urandom_range(0, 4) == 0, rd);
        end
        finish_run();
    end
endmodule